// File: doc/BRIEF.md
# MMU Fault Status Generator

This block sits between a load/store/fetch unit and an external TLB lookup. Each request brings the virtual address, the access kind and the lookup result. The block then decides whether translation applies at all. That depends on the MMU configuration bits and on the virtual-mode bit of the machine status register.

When translation is off, or the MMU is not implemented, the page address passes straight through with full access rights. When translation is on and the lookup hits, the block forms the physical page address from the entry's bases. When the lookup misses or reports a protection violation, the block captures the whole faulting virtual address and an encoded status word, and it raises a one-cycle exception request.

A fault that arrives while an earlier MMU exception has not yet been acknowledged is reported on a separate recursive-fault flag instead. All outputs come from registers and appear one clock after the request.

Top module: `mfsg_top`

## Requirements
- R1: The MMU counts as available only when `cfg_mmu_present` is 1 and, if `cfg_full_set` is 1, `cfg_ext_mmu` is also 1. In every other case the block behaves as if no MMU exists.
- R2: When the MMU is unavailable or `msr_vm` is 0, a request produces, one cycle later, a one-cycle `pa_valid` pulse. It also sets `pa_out` to the virtual address with its low PAGE_BITS bits cleared and `pa_full_rights` to 1. No exception or recursive-fault pulse is raised.
- R3: When translation is on and `lk_hit` is 1, `pa_out` becomes ((`lk_pbase` + page-aligned `va` − `lk_vbase`) mod 2^AW) with the low PAGE_BITS bits cleared. `pa_full_rights` becomes 0 and `pa_valid` pulses.
- R4: On a translated request with `lk_hit` 0, `ear_out` takes the full unaligned `va`. `ear_out` and `esr_out` change on no other event.
- R5: A protection fault (`lk_miss` 0) writes code 17 into `esr_out[4:0]` for a fetch (`acc_type` 2) and code 16 for a load (0) or a store (1).
- R6: A lookup miss (`lk_miss` 1) writes code 19 for a fetch and code 18 for a data access.
- R7: `esr_out[10]` is 1 exactly when the faulting access is a store (`acc_type` 1). All other ESR bits are 0. `acc_type` 3 is treated as a load.
- R8: A fault with no exception pending gives a single-cycle `exc_req` in the same cycle that `ear_out`/`esr_out` update. It gives no `pa_valid`, and it leaves an exception pending.
- R9: A fault while an exception is pending and `exc_ack` is 0 pulses `recur_err` instead of `exc_req`, still updating `ear_out`/`esr_out`. `exc_ack` clears the pending state; if it comes in the same cycle as a fault, that fault counts as a normal one.
- R10: A cycle with `req_valid` 0 produces no pulse, and `pa_out`, `pa_full_rights`, `ear_out` and `esr_out` hold their values.
- R11: After reset all outputs are 0 and no exception is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mmu_present | input | 1 | Basic configuration reports an MMU |
| cfg_full_set | input | 1 | Full configuration set is implemented |
| cfg_ext_mmu | input | 1 | Extended configuration reports MMU use |
| msr_vm | input | 1 | Virtual-mode bit of the machine status register |
| req_valid | input | 1 | An access is presented this cycle |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| va | input | AW | Virtual address of the access |
| lk_hit | input | 1 | TLB lookup hit |
| lk_miss | input | 1 | On a non-hit: 1 miss, 0 protection violation |
| lk_vbase | input | AW | Virtual base of the matched entry |
| lk_pbase | input | AW | Physical base of the matched entry |
| exc_ack | input | 1 | Exception taken; clears the pending state |
| pa_valid | output | 1 | One-cycle pulse: `pa_out` holds a new page address |
| pa_out | output | AW | Physical page address |
| pa_full_rights | output | 1 | Address came from the identity bypass |
| ear_out | output | AW | Captured faulting address |
| esr_out | output | ESR_W | Encoded exception status |
| exc_req | output | 1 | One-cycle MMU exception request |
| recur_err | output | 1 | One-cycle recursive-fault flag |

## Verification
Some rules can be checked on every cycle, and the assertions cover those:
- `exc_req` and `recur_err` never fire together, and neither fires alongside `pa_valid`.
- `ear_out` moves only on a fault pulse.
- Every raised status word carries one of the four legal codes, and a store flag never comes with a fetch code.
- A recursive flag always follows a pending exception.
- Output addresses are page aligned.

The exact values need the bench's sweep, which crosses every configuration combination with the virtual-mode bit, all access kinds, hit/miss/protection outcomes and address pairs that wrap. Those values are the translated page address arithmetic, the identity bypass, the per-kind codes and the store bit. The timing of the acknowledge against back-to-back faults is also shown only by directed scenarios.

// File: rtl/mfsg_pkg.sv
package mfsg_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int          CODE_W         = 5;
  localparam logic [4:0]  CODE_PROT_DATA = 5'd16;
  localparam logic [4:0]  CODE_PROT_INST = 5'd17;
  localparam logic [4:0]  CODE_MISS_DATA = 5'd18;
  localparam logic [4:0]  CODE_MISS_INST = 5'd19;
  localparam int          STORE_BIT      = 10;

endpackage

// File: rtl/mfsg_avail.sv
module mfsg_avail (
  input  logic cfg_mmu_present,
  input  logic cfg_full_set,
  input  logic cfg_ext_mmu,
  input  logic msr_vm,
  output logic mmu_avail,
  output logic xlate_on
);

  logic ext_veto;

  always_comb begin
    ext_veto  = cfg_full_set & ~cfg_ext_mmu;
    mmu_avail = cfg_mmu_present & ~ext_veto;
    xlate_on  = mmu_avail & msr_vm;
  end

endmodule

// File: rtl/mfsg_xlate.sv
module mfsg_xlate #(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic          xlate_on,
  input  logic [AW-1:0] va,
  input  logic [AW-1:0] lk_vbase,
  input  logic [AW-1:0] lk_pbase,
  output logic [AW-1:0] pa_page
);

  localparam int HI_W = AW - PAGE_BITS;

  logic [AW-1:0] page_mask;
  logic [AW-1:0] va_page;
  logic [AW-1:0] mapped;
  logic [AW-1:0] sel;

  generate
    if (PAGE_BITS == 0) begin : g_nopage
      assign page_mask = '1;
    end else begin : g_page
      assign page_mask = {{HI_W{1'b1}}, {PAGE_BITS{1'b0}}};
    end
  endgenerate

  always_comb begin
    va_page = va & page_mask;
    mapped  = lk_pbase + (va_page - lk_vbase);
    sel     = xlate_on ? mapped : va_page;
    pa_page = sel & page_mask;
  end

endmodule

// File: rtl/mfsg_encode.sv
module mfsg_encode
  import mfsg_pkg::*;
#(
  parameter int ESR_W = 32
) (
  input  logic [1:0]       acc_type,
  input  logic             lk_miss,
  output logic [ESR_W-1:0] esr_word
);

  acc_e          kind;
  logic          is_fetch;
  logic          is_store;
  logic [4:0]    code;

  always_comb begin
    kind     = acc_e'(acc_type);
    is_fetch = (kind == ACC_FETCH);
    is_store = (kind == ACC_STORE);
    unique case ({lk_miss, is_fetch})
      2'b00:   code = CODE_PROT_DATA;
      2'b01:   code = CODE_PROT_INST;
      2'b10:   code = CODE_MISS_DATA;
      default: code = CODE_MISS_INST;
    endcase
    esr_word                = '0;
    esr_word[CODE_W-1:0]    = code;
    esr_word[STORE_BIT]     = is_store;
  end

endmodule

// File: rtl/mfsg_top.sv
module mfsg_top
  import mfsg_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int ESR_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_mmu_present,
  input  logic             cfg_full_set,
  input  logic             cfg_ext_mmu,
  input  logic             msr_vm,
  input  logic             req_valid,
  input  logic [1:0]       acc_type,
  input  logic [AW-1:0]    va,
  input  logic             lk_hit,
  input  logic             lk_miss,
  input  logic [AW-1:0]    lk_vbase,
  input  logic [AW-1:0]    lk_pbase,
  input  logic             exc_ack,
  output logic             pa_valid,
  output logic [AW-1:0]    pa_out,
  output logic             pa_full_rights,
  output logic [ESR_W-1:0] esr_out,
  output logic [AW-1:0]    ear_out,
  output logic             exc_req,
  output logic             recur_err
);

  logic             mmu_avail;
  logic             xlate_on;
  logic [AW-1:0]    pa_page;
  logic [ESR_W-1:0] esr_word;

  // next-state signals
  logic             fault;
  logic             pa_en;
  logic             pend_live;
  logic             exc_d;
  logic             rec_d;
  logic             pend_d;
  logic             pend_q;

  mfsg_avail u_avail (
    .cfg_mmu_present (cfg_mmu_present),
    .cfg_full_set    (cfg_full_set),
    .cfg_ext_mmu     (cfg_ext_mmu),
    .msr_vm          (msr_vm),
    .mmu_avail       (mmu_avail),
    .xlate_on        (xlate_on)
  );

  mfsg_xlate #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_xlate (
    .xlate_on (xlate_on),
    .va       (va),
    .lk_vbase (lk_vbase),
    .lk_pbase (lk_pbase),
    .pa_page  (pa_page)
  );

  mfsg_encode #(.ESR_W(ESR_W)) u_encode (
    .acc_type (acc_type),
    .lk_miss  (lk_miss),
    .esr_word (esr_word)
  );

  // next-state process
  always_comb begin
    fault     = req_valid & xlate_on & ~lk_hit;
    pa_en     = req_valid & (~xlate_on | lk_hit);
    pend_live = pend_q & ~exc_ack;
    exc_d     = fault & ~pend_live;
    rec_d     = fault & pend_live;
    if (exc_d)        pend_d = 1'b1;
    else if (exc_ack) pend_d = 1'b0;
    else              pend_d = pend_q;
  end

  // pulse and pending registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_valid  <= 1'b0;
      exc_req   <= 1'b0;
      recur_err <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      pa_valid  <= pa_en;
      exc_req   <= exc_d;
      recur_err <= rec_d;
      pend_q    <= pend_d;
    end
  end

  // address path register, enabled on a produced address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_out         <= '0;
      pa_full_rights <= 1'b0;
    end else if (pa_en) begin
      pa_out         <= pa_page;
      pa_full_rights <= ~xlate_on;
    end
  end

  // fault capture register, enabled on any fault
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ear_out <= '0;
      esr_out <= '0;
    end else if (fault) begin
      ear_out <= va;
      esr_out <= esr_word;
    end
  end

  // R8: exception and recursive flags are exclusive, and neither comes with an address
  a_r8_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_req, recur_err, pa_valid}));

  // R4: capture registers move only on a fault pulse
  a_r4_ear_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_req || recur_err) |-> ($stable(ear_out) && $stable(esr_out)));

  // R5 / R6: only the four legal codes appear with a request
  a_r5_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (esr_out[4:2] == 3'b100));

  // R7: store flag never with an instruction-fetch code
  a_r7_store_data: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && esr_out[STORE_BIT]) |-> !esr_out[0]);

  // R9: a recursive flag needs an exception already pending
  a_r9_recur_pending: assert property (@(posedge clk) disable iff (!rst_n)
    recur_err |-> $past(pend_q));

  // R3: produced addresses are page aligned
  a_r3_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pa_valid |-> ((pa_out & ~({AW{1'b1}} << PAGE_BITS)) == '0));

endmodule

// File: tb/mfsg_top_tb_top.sv
`timescale 1ns/1ps
module mfsg_top_tb_top;

  localparam int AW = 16;
  localparam int PB = 4;
  localparam int EW = 16;
  localparam logic [15:0] MASK = 16'hFFF0;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_p, cfg_f, cfg_e, vm, rv, hit, miss, ack;
  logic [1:0]  acc;
  logic [15:0] va, vb, pb;
  logic        pa_valid, pa_full, exc_req, recur_err;
  logic [15:0] pa_out, ear_out, esr_out;

  int n_vec = 0;
  int n_bad = 0;

  logic [15:0] m_pa, m_ear, m_esr;
  logic        m_full;

  always #2.5 clk = ~clk;

  mfsg_top #(.AW(AW), .PAGE_BITS(PB), .ESR_W(EW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_mmu_present(cfg_p), .cfg_full_set(cfg_f), .cfg_ext_mmu(cfg_e),
    .msr_vm(vm), .req_valid(rv), .acc_type(acc), .va(va),
    .lk_hit(hit), .lk_miss(miss), .lk_vbase(vb), .lk_pbase(pb),
    .exc_ack(ack),
    .pa_valid(pa_valid), .pa_out(pa_out), .pa_full_rights(pa_full),
    .esr_out(esr_out), .ear_out(ear_out), .exc_req(exc_req), .recur_err(recur_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected pulses, address outputs and capture registers
  task automatic check_all(input string req, input logic e_pa, input logic e_exc, input logic e_rec);
    check({req, " pa_valid"}, {31'd0, pa_valid}, {31'd0, e_pa});
    check({req, " exc_req"},  {31'd0, exc_req},  {31'd0, e_exc});
    check({req, " recur_err"},{31'd0, recur_err},{31'd0, e_rec});
    check({req, " pa_out"},   {16'd0, pa_out},   {16'd0, m_pa});
    check({req, " full"},     {31'd0, pa_full},  {31'd0, m_full});
    check({req, " ear"},      {16'd0, ear_out},  {16'd0, m_ear});
    check({req, " esr"},      {16'd0, esr_out},  {16'd0, m_esr});
  endtask

  function automatic logic [15:0] exp_esr(input logic [1:0] a, input logic ms);
    logic [15:0] w;
    w = ms ? 16'd18 : 16'd16;
    if (a == 2'd2) w = w + 16'd1;
    if (a == 2'd1) w = w | 16'h0400;
    return w;
  endfunction

  task automatic idle();
    @(negedge clk);
    rv = 1'b0; ack = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {cfg_p, cfg_f, cfg_e, vm, rv, hit, miss, ack} = '0;
    acc = 2'd0; va = '0; vb = '0; pb = '0;
    m_pa = '0; m_ear = '0; m_esr = '0; m_full = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check_all("R11", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R11", 1'b0, 1'b0, 1'b0);

    // sweep: R1 R2 R3 R4 R5 R6 R7 R8
    for (int c = 0; c < 8; c++) begin
      for (int v = 0; v < 2; v++) begin
        for (int a = 0; a < 4; a++) begin
          for (int o = 0; o < 3; o++) begin
            for (int s = 0; s < 2; s++) begin
              logic avail, on, e_pa, e_exc;
              cfg_p = c[0]; cfg_f = c[1]; cfg_e = c[2]; vm = v[0];
              acc = 2'(a);
              hit = (o == 0); miss = (o == 2);
              if (s == 0) begin va = 16'h1237; vb = 16'h1200; pb = 16'hA340; end
              else        begin va = 16'h0F5C; vb = 16'h3000; pb = 16'h0010; end
              rv = 1'b1; ack = 1'b0;
              avail = cfg_p & (~cfg_f | cfg_e);
              on    = avail & vm;
              e_pa  = ~on | hit;
              e_exc = on & ~hit;
              if (e_pa) begin
                m_full = ~on;
                m_pa   = on ? ((pb + (va & MASK) - vb) & MASK) : (va & MASK);
              end else begin
                m_ear = va;
                m_esr = exp_esr(acc, miss);
              end
              @(negedge clk);
              rv = 1'b0;
              if (!on)      check_all("R1_R2", e_pa, e_exc, 1'b0);
              else if (hit) check_all("R3", e_pa, e_exc, 1'b0);
              else if (miss) check_all("R6_R7_R8", e_pa, e_exc, 1'b0);
              else          check_all("R5_R7_R8", e_pa, e_exc, 1'b0);
              ack = e_exc;
              @(negedge clk);
              ack = 1'b0;
              // R10: no request, nothing moves
              check_all("R10", 1'b0, 1'b0, 1'b0);
            end
          end
        end
      end
    end

    // R9: recursive fault
    cfg_p = 1'b1; cfg_f = 1'b0; cfg_e = 1'b0; vm = 1'b1; hit = 1'b0;
    miss = 1'b1; acc = 2'd2; va = 16'h4444; rv = 1'b1; ack = 1'b0;
    m_ear = 16'h4444; m_esr = 16'd19;
    @(negedge clk);
    check_all("R9 first", 1'b0, 1'b1, 1'b0);
    miss = 1'b0; acc = 2'd1; va = 16'h5A5B;
    m_ear = 16'h5A5B; m_esr = 16'h0410;
    @(negedge clk);
    check_all("R9 recursive", 1'b0, 1'b0, 1'b1);
    // ack in same cycle as fault: normal exception
    acc = 2'd0; miss = 1'b1; va = 16'h7001; ack = 1'b1;
    m_ear = 16'h7001; m_esr = 16'd18;
    @(negedge clk);
    check_all("R9 ack same cycle", 1'b0, 1'b1, 1'b0);
    // still pending from that fault: next fault is recursive
    ack = 1'b0; va = 16'h7002; m_ear = 16'h7002;
    @(negedge clk);
    check_all("R9 pending kept", 1'b0, 1'b0, 1'b1);
    rv = 1'b0; ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check_all("R10 ack only", 1'b0, 1'b0, 1'b0);
    rv = 1'b1; va = 16'h7003; m_ear = 16'h7003;
    @(negedge clk);
    check_all("R9 cleared", 1'b0, 1'b1, 1'b0);
    idle();
    // R10: lookup inputs toggle with req_valid low
    hit = 1'b1; va = 16'hFFFF; pb = 16'h1111; acc = 2'd1;
    repeat (2) @(negedge clk);
    check_all("R10 idle", 1'b0, 1'b0, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule